// File: doc/BRIEF.md
# Rounding Saturating Sample Narrower

This block takes unsigned 14-bit samples, typically straight from an ADC, and turns each one into an unsigned 8-bit sample that a byte-wide transmitter can carry. It drops the six least significant bits. By default it rounds to the nearest 8-bit level: it adds half of one output step before it drops the bits. Plain truncation is also available as a build-time option, at the cost of more truncation noise.

Rounding can carry past the top of the 8-bit range. This happens only when input bits [13:5] are all ones. The block detects that case and clamps the output to full scale (0xFF), so the output never wraps to a small value.

The result is registered. An input valid strobe qualifies each sample, and an output valid strobe follows it one clock later. Between valid samples, the output register holds its last value.

Top module: `sample_scaler`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, `out_data` is 0x00 and `out_vld` is 0.
- R2: `out_vld` equals `in_vld` from the previous rising clock edge; the latency is exactly one clock.
- R3: With rounding enabled (`ROUND_EN`=1), a valid sample that does not saturate produces `out_data` = (`in_data` + 32) >> 6, one clock later.
- R4: With rounding enabled, a valid sample whose bits [13:5] are all ones produces `out_data` = 0xFF. This covers inputs 0x3FE0 through 0x3FFF.
- R5: On a clock where `in_vld` is 0, `out_data` keeps its previous value, whatever `in_data` carries.
- R6: The rounding threshold sits at half an output step: input 0x001F gives 0x00 and input 0x0020 gives 0x01.
- R7: Input 0x3FDF reaches 0xFF through ordinary rounding, without saturation. The next input, 0x3FE0, is the first one that saturates, and it also gives 0xFF.
- R8: With rounding disabled (`ROUND_EN`=0), a valid sample produces `out_data` = `in_data` >> 6, which is plain truncation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Qualifies `in_data` on this clock |
| in_data | input | IN_W (14) | Unsigned wide sample |
| out_vld | output | 1 | Registered sample is new this cycle |
| out_data | output | OUT_W (8) | Unsigned narrowed sample |

## Verification
A fault in the carry or clamp logic shows up on `out_data` in the very next cycle after the triggering sample. The samples that expose it lie around the half-step threshold and at the top of the input range. There, a wrap appears as a small value where 0xFF is expected. A fault in the enable of the output register shows up as a change in `out_data` during an idle cycle. A fault in the valid pipeline shows up as `out_vld` rising one cycle early or late. Each of these faults is therefore visible at the ports within one clock of the stimulus that provokes it.

// File: rtl/sample_scaler.sv
module sample_scaler #(
  parameter int IN_W     = 14,
  parameter int OUT_W    = 8,
  parameter bit ROUND_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_data
);
  localparam int DROP = IN_W - OUT_W;

  logic [OUT_W-1:0] scaled;

  generate
    if (ROUND_EN) begin : g_round
      logic             sat;
      logic [OUT_W-1:0] sum;
      assign sat    = &in_data[IN_W-1:DROP-1];
      assign sum    = in_data[IN_W-1:DROP] + {{(OUT_W-1){1'b0}}, in_data[DROP-1]};
      assign scaled = sat ? {OUT_W{1'b1}} : sum;
    end else begin : g_trunc
      logic unused_low;
      assign unused_low = ^in_data[DROP-1:0];
      assign scaled     = in_data[IN_W-1:DROP];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_data <= scaled;
    end
  end
endmodule

// File: rtl/sample_scaler_chk.sv
module sample_scaler_chk #(
  parameter int IN_W     = 14,
  parameter int OUT_W    = 8,
  parameter bit ROUND_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [IN_W-1:0]  in_data,
  input logic             out_vld,
  input logic [OUT_W-1:0] out_data
);
  localparam int DROP = IN_W - OUT_W;
  localparam logic [IN_W:0] HALF = (IN_W+1)'(1) << (DROP-1);

  always @(posedge clk)
    if (!rst_n) p_reset_r1: assert (out_vld == 1'b0 && out_data == '0);

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_vld == $past(in_vld));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_data));

  generate
    if (ROUND_EN) begin : g_round_chk
      p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && (&in_data[IN_W-1:DROP-1]) |=> out_data == {OUT_W{1'b1}});
      p_round_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && !(&in_data[IN_W-1:DROP-1]) |=>
          out_data == OUT_W'(({1'b0, $past(in_data)} + HALF) >> DROP));
    end else begin : g_trunc_chk
      p_trunc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_data == OUT_W'($past(in_data) >> DROP));
    end
  endgenerate
endmodule

bind sample_scaler sample_scaler_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .ROUND_EN(ROUND_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
  .out_vld(out_vld), .out_data(out_data)
);

// File: tb/sample_scaler_tb.sv
module sample_scaler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  localparam logic [21:0] VEC [NVEC] = '{
    {14'h0000, 8'h00}, {14'h001F, 8'h00}, {14'h0020, 8'h01},
    {14'h005F, 8'h01}, {14'h0060, 8'h02}, {14'h0ABC, 8'h2B},
    {14'h1234, 8'h49}, {14'h1FFF, 8'h80}, {14'h2000, 8'h80},
    {14'h3FDF, 8'hFF}, {14'h3FE0, 8'hFF}, {14'h3FFF, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [13:0] in_data = '0;
  logic out_vld, tr_vld;
  logic [7:0] out_data, tr_data;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_scaler u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld), .out_data(out_data));

  sample_scaler #(.ROUND_EN(1'b0)) u_dut_trunc (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .out_vld(tr_vld), .out_data(tr_data));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [13:0] d, input logic v);
    @(negedge clk);
    in_data = d;
    in_vld  = v;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*3);
    check("R1 out_data in reset", out_data, 8'h00);
    check("R1 out_vld in reset", {7'b0, out_vld}, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][21:8], 1'b1);
      check("R3/R4/R6/R7 rounded value", out_data, VEC[i][7:0]);
      check("R2 out_vld follows in_vld", {7'b0, out_vld}, 8'h01);
      check("R8 truncated value", tr_data, 8'(VEC[i][21:8] >> 6));
    end

    send(14'h0020, 1'b1);
    check("R6 threshold high side", out_data, 8'h01);
    send(14'h001F, 1'b1);
    check("R6 threshold low side", out_data, 8'h00);
    send(14'h3FDF, 1'b1);
    check("R7 rounding reaches full scale", out_data, 8'hFF);
    send(14'h3FE0, 1'b1);
    check("R4 first saturating input", out_data, 8'hFF);

    send(14'h1234, 1'b1);
    check("R3 load before idle", out_data, 8'h49);
    send(14'h3FFF, 1'b0);
    check("R5 hold while idle", out_data, 8'h49);
    check("R2 out_vld low after idle", {7'b0, out_vld}, 8'h00);
    check("R5 trunc hold while idle", tr_data, 8'h48);
    send(14'h0000, 1'b0);
    check("R5 hold second idle", out_data, 8'h49);
    send(14'h0ABC, 1'b1);
    check("R2 out_vld rises one cycle later", {7'b0, out_vld}, 8'h01);

    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1 async clear data", out_data, 8'h00);
    check("R1 async clear valid", {7'b0, out_vld}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule